// File: doc/BRIEF.md
# Watchdog Configuration Write Guard

This block holds the control settings of a watchdog timer (a control word carrying clock select, divider, window and unlock-method fields, the interrupt and reset timeout values, and the error response enables) and keeps stray writes from changing them. The control word's lowest bit is a lock. While the lock is clear, every configuration write is taken at once. Once the lock is set, configuration writes are refused unless software first opens a short write window.

The protection word packs an unlock code in its low half and an update period in its high half. Software opens the window by reading that word and writing the same value back. The window then stays open for the period times 128 bus clock cycles. A write-back that does not match is logged as an unlock failure. A configuration write that arrives while the block is locked and no window is open is dropped and logged as a violation.

All stored configuration is covered by one even-parity bit. That bit is recomputed on each accepted write and compared on every cycle, so corruption of the stored bits is caught. Each logged failure can be routed to an interrupt line, to a reset request line, or to both.

Top module: `cfg_guard`

## Requirements
- R1: After reset the control word (address 0) reads 0, so the lock is clear, and the protection word (address 3) reads {DEF_PER, DEF_PASS}, which is 32'h0004_ECF9 by default. The timeout words (addresses 1 and 2) read DEF_TINT and DEF_TRST, status and enables read 0, and wr_allowed is 1.
- R2: While the lock (control bit 0) is clear, a write to address 0, 1, 2, 3 or 5 stores its data on the next clock edge. Address 5 keeps only bits 7:2.
- R3: While the lock is set and no window is open, a write to address 0, 1, 2 or 5 leaves the stored value unchanged and sets status bit 2 (violation).
- R4: Status sits at address 4 and is write-one-to-clear. Only bits 2, 3 and 6 can ever be 1.
- R5: While the lock is set and no window is open, a write to address 3 whose data differs from the stored protection word leaves that word unchanged, opens no window and sets status bit 3 (unlock failure).
- R6: While the lock is set, a write to address 3 whose data equals the stored protection word opens the write window. From the next cycle, wr_allowed is 1 and configuration writes are stored.
- R7: The window lasts P×128 clock cycles after the unlocking edge, where P is bits 31:16 of the protection word, and P = 0 gives no window at all. While a window is open, a non-matching write to address 3 stores the new word.
- R8: An even-parity bit over all stored configuration is recomputed on every accepted write. A mismatch on any cycle sets status bit 6 at the next edge, and it keeps setting that bit until a later accepted write restores agreement. The err_inject input inverts the stored parity bit.
- R9: irq is the OR of status bit 6 AND enable bit 2, status bit 3 AND enable bit 4, and status bit 2 AND enable bit 6. rst_req is the same OR using enable bits 3, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| err_inject | input | 1 | Inverts the stored parity bit |
| cfg_ctrl | output | 32 | Stored control word |
| cfg_tout_int | output | 32 | Stored interrupt timeout value |
| cfg_tout_rst | output | 32 | Stored reset timeout value |
| cfg_locked | output | 1 | Lock bit of the control word |
| wr_allowed | output | 1 | Configuration writes are currently accepted |
| status | output | 8 | Sticky failure flags (bits 2, 3, 6) |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request |

## Verification
The bench measures the window edge exactly. It checks that the window is still open after 127 cycles and closed after 128, because a counter that is off by one would either leave a gap or add an extra cycle for writes. It also checks that a zero period opens nothing, which a counter that wraps around would get wrong by granting a huge window. For parity, it confirms that clearing the flag does not help while the stored bit still disagrees, and that only a real write clears the fault; a design that cleared the mismatch on acknowledge would hide the corruption. Two further checks cover the case where refused writes could still update data or the protection word, and the case where enables are routed to the wrong output line.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    localparam int ADDR_W = 3;
    localparam int EN_W   = 8;
    localparam int STAT_W = 8;
    localparam int N_SRC  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_TINT = 3'd1,
        A_TRST = 3'd2,
        A_PROT = 3'd3,
        A_STAT = 3'd4,
        A_EN   = 3'd5
    } reg_addr_e;

    // failure sources: 0 parity, 1 unlock failure, 2 update violation
    function automatic int src_stat_bit(input int i);
        case (i)
            0:       return 6;
            1:       return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int src_int_bit(input int i);
        case (i)
            0:       return 2;
            1:       return 4;
            default: return 6;
        endcase
    endfunction

    function automatic logic [EN_W-1:0] en_keep_mask();
        logic [EN_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_SRC; i++) begin
            m[src_int_bit(i)]     = 1'b1;
            m[src_int_bit(i) + 1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg_guard_window.sv
module cfg_guard_window #(
    parameter int PER_W     = 16,
    parameter int GRAN_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PER_W-1:0] period,
    output logic             open
);
    localparam int CNT_W = PER_W + GRAN_LOG2;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = {period, {GRAN_LOG2{1'b0}}};
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign open = (cnt_q != '0);
endmodule

// File: rtl/cfg_guard_parity.sv
module cfg_guard_parity #(
    parameter int W = 136
) (
    input  logic [W-1:0] vec,
    output logic         par
);
    localparam int NW = (W + 7) / 8;

    logic [NW*8-1:0] padded;
    logic [NW-1:0]   part;

    assign padded = {{(NW*8-W){1'b0}}, vec};

    for (genvar g = 0; g < NW; g++) begin : g_byte
        assign part[g] = ^padded[g*8 +: 8];
    end

    assign par = ^part;
endmodule

// File: rtl/cfg_guard_events.sv
module cfg_guard_events
    import cfg_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_hit,
    input  logic              clr_en,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic [EN_W-1:0]   en_mask,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              rst_req
);
    logic [STAT_W-1:0] stat_d, stat_q;
    logic [N_SRC-1:0]  set_vec, keep_vec, int_vec, rst_vec;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam int SB = src_stat_bit(g);
        localparam int IB = src_int_bit(g);
        assign set_vec[g]  = src_hit[g];
        assign keep_vec[g] = stat_q[SB] & ~(clr_en & clr_mask[SB]);
        assign int_vec[g]  = stat_q[SB] & en_mask[IB];
        assign rst_vec[g]  = stat_q[SB] & en_mask[IB + 1];
    end

    always_comb begin
        stat_d = '0;
        for (int i = 0; i < N_SRC; i++) begin
            stat_d[src_stat_bit(i)] = set_vec[i] | keep_vec[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign status  = stat_q;
    assign irq     = |int_vec;
    assign rst_req = |rst_vec;
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int                         DATA_W    = 32,
    parameter int                         PER_W     = 16,
    parameter int                         GRAN_LOG2 = 7,
    parameter logic [DATA_W-PER_W-1:0]    DEF_PASS  = 'hECF9,
    parameter logic [PER_W-1:0]           DEF_PER   = 'd4,
    parameter logic [DATA_W-1:0]          DEF_TINT  = 'h0000_1000,
    parameter logic [DATA_W-1:0]          DEF_TRST  = 'h0000_2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              err_inject,
    output logic [DATA_W-1:0] cfg_ctrl,
    output logic [DATA_W-1:0] cfg_tout_int,
    output logic [DATA_W-1:0] cfg_tout_rst,
    output logic              cfg_locked,
    output logic              wr_allowed,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              rst_req
);
    localparam int PASS_W = DATA_W - PER_W;
    localparam int CFG_W  = 4 * DATA_W + EN_W;
    localparam logic [EN_W-1:0] EN_KEEP = en_keep_mask();

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] tint;
        logic [DATA_W-1:0] trst;
        logic [DATA_W-1:0] prot;
        logic [EN_W-1:0]   en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic par_d, par_q;

    logic win_open, writable, lock;
    logic hit_cfg, acc_cfg, viol;
    logic prot_wr, prot_match, unlock, ufail, pstore;
    logic par_new, par_now, mismatch;

    assign lock     = cfg_q.ctrl[0];
    assign writable = ~lock | win_open;

    always_comb begin
        hit_cfg = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL, A_TINT, A_TRST, A_EN: hit_cfg = 1'b1;
                default:                      hit_cfg = 1'b0;
            endcase
        end
    end

    assign acc_cfg    = hit_cfg & writable;
    assign viol       = hit_cfg & ~writable;
    assign prot_wr    = wr_en & (wr_addr == A_PROT);
    assign prot_match = (wr_data == cfg_q.prot);
    assign unlock     = prot_wr & lock & prot_match;
    assign ufail      = prot_wr & lock & ~prot_match & ~win_open;
    assign pstore     = prot_wr & ~prot_match & writable;

    always_comb begin
        cfg_d = cfg_q;
        if (acc_cfg) begin
            case (wr_addr)
                A_CTRL:  cfg_d.ctrl = wr_data;
                A_TINT:  cfg_d.tint = wr_data;
                A_TRST:  cfg_d.trst = wr_data;
                default: cfg_d.en   = wr_data[EN_W-1:0] & EN_KEEP;
            endcase
        end
        if (pstore) begin
            cfg_d.prot = wr_data;
        end
    end

    cfg_guard_parity #(.W(CFG_W)) u_par_new (.vec(cfg_d), .par(par_new));
    cfg_guard_parity #(.W(CFG_W)) u_par_now (.vec(cfg_q), .par(par_now));

    assign mismatch = (par_now != par_q);

    always_comb begin
        if (acc_cfg | pstore) begin
            par_d = par_new;
        end else begin
            par_d = par_q ^ err_inject;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{ctrl: '0, tint: DEF_TINT, trst: DEF_TRST,
                       prot: {DEF_PER, DEF_PASS}, en: '0};
            par_q <= ^{DEF_TINT, DEF_TRST, DEF_PER, DEF_PASS};
        end else begin
            cfg_q <= cfg_d;
            par_q <= par_d;
        end
    end

    cfg_guard_window #(.PER_W(PER_W), .GRAN_LOG2(GRAN_LOG2)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (unlock),
        .period (wr_data[DATA_W-1:PASS_W]),
        .open   (win_open)
    );

    cfg_guard_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_hit  ({viol, ufail, mismatch}),
        .clr_en   (wr_en && (wr_addr == A_STAT)),
        .clr_mask (wr_data[STAT_W-1:0]),
        .en_mask  (cfg_q.en),
        .status   (status),
        .irq      (irq),
        .rst_req  (rst_req)
    );

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = cfg_q.ctrl;
            A_TINT:  rd_data = cfg_q.tint;
            A_TRST:  rd_data = cfg_q.trst;
            A_PROT:  rd_data = cfg_q.prot;
            A_STAT:  rd_data = {{(DATA_W-STAT_W){1'b0}}, status};
            A_EN:    rd_data = {{(DATA_W-EN_W){1'b0}}, cfg_q.en};
            default: rd_data = '0;
        endcase
    end

    assign cfg_ctrl     = cfg_q.ctrl;
    assign cfg_tout_int = cfg_q.tint;
    assign cfg_tout_rst = cfg_q.trst;
    assign cfg_locked   = lock;
    assign wr_allowed   = writable;
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic              cfg_locked,
    input logic              wr_allowed,
    input logic [DATA_W-1:0] cfg_tout_int,
    input logic [7:0]        status,
    input logic              irq,
    input logic              rst_req
);
    AST_UNLOCKED_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_locked |-> wr_allowed); // R2

    AST_REFUSED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1 && !wr_allowed) |=> $stable(cfg_tout_int)); // R3

    AST_REFUSED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1 && !wr_allowed) |=> status[2]); // R3

    AST_STATUS_DEFINED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (status & 8'hB3) == 8'h00); // R4

    AST_NO_FLAG_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h00) |-> (!irq && !rst_req)); // R9
endmodule

bind cfg_guard cfg_guard_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .cfg_locked   (cfg_locked),
    .wr_allowed   (wr_allowed),
    .cfg_tout_int (cfg_tout_int),
    .status       (status),
    .irq          (irq),
    .rst_req      (rst_req)
);

// File: tb/cfg_guard_tb_top.sv
module cfg_guard_tb_top;
    localparam int CLK_PERIOD = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        err_inject = 1'b0;
    logic [31:0] cfg_ctrl, cfg_tout_int, cfg_tout_rst;
    logic        cfg_locked, wr_allowed, irq, rst_req;
    logic [7:0]  status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 read, 1 wr_allowed, 2 irq, 3 rst_req, 4 cfg_locked
        logic [2:0]  addr;
        logic [31:0] value;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_guard dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .err_inject(err_inject),
        .cfg_ctrl(cfg_ctrl), .cfg_tout_int(cfg_tout_int), .cfg_tout_rst(cfg_tout_rst),
        .cfg_locked(cfg_locked), .wr_allowed(wr_allowed), .status(status),
        .irq(irq), .rst_req(rst_req)
    );

    task automatic exp_rd(input logic [2:0] a, input logic [31:0] v, input string t);
        item_t it;
        it.kind = 0; it.addr = a; it.value = v; it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic exp_sig(input int k, input logic v, input string t);
        item_t it;
        it.kind = k; it.addr = '0; it.value = {31'd0, v}; it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic inject();
        @(negedge clk);
        err_inject = 1'b1;
        @(negedge clk);
        err_inject = 1'b0;
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0: begin rd_addr = it.addr; #1; act = rd_data; end
                    1: act = {31'd0, wr_allowed};
                    2: act = {31'd0, irq};
                    3: act = {31'd0, rst_req};
                    default: act = {31'd0, cfg_locked};
                endcase
                total++;
                if (act !== it.value) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.value);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        exp_rd(3'd0, 32'h0, "R1 ctrl");
        exp_rd(3'd3, 32'h0004_ECF9, "R1 prot");
        exp_rd(3'd1, 32'h0000_1000, "R1 tint");
        exp_rd(3'd4, 32'h0, "R1 status");
        exp_sig(1, 1'b1, "R1 wr_allowed");

        // R2 unlocked writes
        wr(3'd1, 32'h0000_AAAA);
        exp_rd(3'd1, 32'h0000_AAAA, "R2 tint");
        wr(3'd3, 32'h0001_1234);
        exp_rd(3'd3, 32'h0001_1234, "R2 prot");
        wr(3'd5, 32'h0000_0097);
        exp_rd(3'd5, 32'h0000_0094, "R2 enables");
        wr(3'd0, 32'h0000_0031);
        exp_sig(4, 1'b1, "R2 locked");
        exp_sig(1, 1'b0, "R3 wr_allowed low");

        // R3 refused write, R9 reset routing
        wr(3'd1, 32'h0000_5555);
        exp_rd(3'd1, 32'h0000_AAAA, "R3 tint held");
        exp_rd(3'd4, 32'h0000_0004, "R3 violation flag");
        exp_sig(3, 1'b1, "R9 rst_req");
        exp_sig(2, 1'b0, "R9 irq");

        // R4 write-one-to-clear
        wr(3'd4, 32'h0000_0004);
        exp_rd(3'd4, 32'h0, "R4 cleared");
        exp_sig(3, 1'b0, "R4 rst_req low");

        // R5 wrong unlock
        wr(3'd3, 32'h0001_1235);
        exp_rd(3'd4, 32'h0000_0008, "R5 unlock fail");
        exp_rd(3'd3, 32'h0001_1234, "R5 prot held");
        exp_sig(1, 1'b0, "R5 no window");
        exp_sig(2, 1'b1, "R9 irq unlock fail");
        wr(3'd4, 32'h0000_0008);

        // R6 correct unlock
        wr(3'd3, 32'h0001_1234);
        exp_sig(1, 1'b1, "R6 window open");
        wr(3'd1, 32'h0000_0F0F);
        exp_rd(3'd1, 32'h0000_0F0F, "R6 tint accepted");
        exp_rd(3'd4, 32'h0, "R6 no flags");

        // R7 window length with P=1
        wr(3'd3, 32'h0001_1234);
        repeat (127) @(negedge clk);
        exp_sig(1, 1'b1, "R7 open at 127");
        @(negedge clk);
        exp_sig(1, 1'b0, "R7 closed at 128");
        wr(3'd2, 32'h0000_7777);
        exp_rd(3'd2, 32'h0000_2000, "R7 trst held");
        exp_rd(3'd4, 32'h0000_0004, "R7 late write flagged");
        wr(3'd4, 32'h0000_0004);

        // R8 parity
        inject();
        @(negedge clk);
        exp_rd(3'd4, 32'h0000_0040, "R8 parity flag");
        exp_sig(2, 1'b1, "R9 irq parity");
        wr(3'd4, 32'h0000_0040);
        exp_rd(3'd4, 32'h0000_0040, "R8 flag persists");
        wr(3'd3, 32'h0001_1234);
        wr(3'd1, 32'h0000_1111);
        wr(3'd4, 32'h0000_0040);
        exp_rd(3'd4, 32'h0, "R8 cleared after rewrite");

        // R7 store in window, then zero period
        wr(3'd3, 32'h0000_1234);
        exp_rd(3'd3, 32'h0000_1234, "R7 prot stored in window");
        wr(3'd3, 32'h0000_1234);
        exp_sig(1, 1'b0, "R7 zero period no window");
        wr(3'd1, 32'h0000_2222);
        exp_rd(3'd1, 32'h0000_1111, "R7 zero period write held");
        exp_rd(3'd4, 32'h0000_0004, "R7 zero period flagged");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule